// File: doc/BRIEF.md
# Remove-and-Insert Permutation Mutator

This block applies a mutation to a tour: a chromosome that lists N distinct city indices in visiting order. Instead of overwriting a gene with a fresh value, which could duplicate one city and lose another, it lifts the gene out of one position and drops it into another. Every gene between the two positions slides by one place to fill the gap. A permutation therefore always comes out as a permutation, and the same block serves any chromosome of that kind.

The random positions come from outside the block, and so does the decision whether to mutate at all. The caller presents the chromosome, the removal position, the insertion position and an enable flag, then pulses `start`. The result is computed combinationally and captured in a register. It appears with `valid` one clock later and is held until the next `start`.

The control is a two-state machine. `ST_IDLE` means no fresh result. `ST_SHOW` means the output register took a result on the last edge. Four transitions are named. In `IDLE_TO_SHOW` and `SHOW_TO_SHOW`, `start` is high. In `SHOW_TO_IDLE` and `IDLE_TO_IDLE`, `start` is low.

Top module: `perm_move_mutator`

## Requirements
- R1: Positions are 1-based. Gene at position p occupies bits [(p-1)*W +: W] of `chrom_in` and `chrom_out`, so position 1 is the least significant field.
- R2: When insertion < removal (mutation active), the gene from the removal position lands at the insertion position, and the genes from insertion to removal-1 each move one place toward the back.
- R3: When insertion > removal (mutation active), the moved gene lands at the insertion position, and the genes from removal+1 to insertion each move one place toward the front.
- R4: Equal removal and insertion positions pass the chromosome through unchanged.
- R5: With `enable` low the chromosome passes through unchanged, whatever the positions.
- R6: A removal or insertion position of 0 or greater than N makes the operation a pass-through.
- R7: `valid` is high in exactly the cycle after a clock edge at which `start` was high, and low otherwise; reset clears `valid` and `chrom_out`.
- R8: `chrom_out` changes only on an edge where `start` is high; input changes without `start` leave it held.
- R9: If the input is a permutation of 0..N-1, the output is a permutation of 0..N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture a result on this edge |
| enable | input | 1 | Mutation permitted |
| rem_pos | input | PW | 1-based removal position |
| ins_pos | input | PW | 1-based insertion position |
| chrom_in | input | N*W | Input chromosome |
| chrom_out | output | N*W | Registered result chromosome |
| valid | output | 1 | Result captured on the previous edge |

## Verification
The bench moves genes between the two end positions in both directions. A shifter that mishandles the first or last slot would show a stale or duplicated city there. Adjacent swaps in both directions catch off-by-one shift bounds, and a wrong bound would leave a gene copied twice; the permutation check on every result reports that as well. The pass-through cases cover an equal pair, a low enable, and positions 0, N+1 and the largest code. These catch a design that indexes modulo the gene count or ignores the enable, because such a design would alter the tour. Separate tests change the inputs with `start` low and check the hold, and check that `valid` drops after one cycle.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } pmm_state_t;
endpackage

// File: rtl/pmm_pos_decode.sv
module pmm_pos_decode #(
    parameter int N  = 8,
    parameter int PW = $clog2(N + 1),
    parameter int IW = $clog2(N)
) (
    input  logic [PW-1:0] rem_pos,
    input  logic [PW-1:0] ins_pos,
    input  logic          enable,
    output logic          active,
    output logic [IW-1:0] rem_idx,
    output logic [IW-1:0] ins_idx
);
    localparam logic [PW-1:0] LAST_POS = PW'(N);

    logic rem_ok;
    logic ins_ok;

    always_comb begin
        rem_ok  = (rem_pos != '0) && (rem_pos <= LAST_POS);
        ins_ok  = (ins_pos != '0) && (ins_pos <= LAST_POS);
        active  = enable && rem_ok && ins_ok && (rem_pos != ins_pos);
        rem_idx = IW'(rem_pos - PW'(1));
        ins_idx = IW'(ins_pos - PW'(1));
    end

    // R6: an active move never carries an out-of-range position
    always_comb begin
        if (active) begin
            p_range_r6: assert ((rem_pos <= LAST_POS) && (ins_pos <= LAST_POS));
        end
    end
endmodule

// File: rtl/pmm_shift_net.sv
module pmm_shift_net #(
    parameter int N  = 8,
    parameter int W  = 3,
    parameter int IW = $clog2(N)
) (
    input  logic [N*W-1:0] chrom_in,
    input  logic           active,
    input  logic [IW-1:0]  rem_idx,
    input  logic [IW-1:0]  ins_idx,
    output logic [N*W-1:0] chrom_out
);
    logic [W-1:0] gene [N];
    logic         toward_back;
    logic [W-1:0] lifted;

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign gene[g] = chrom_in[g*W +: W];
    end

    assign toward_back = ins_idx < rem_idx;
    assign lifted      = gene[rem_idx];

    for (genvar j = 0; j < N; j++) begin : g_slot
        localparam int          LOWER = (j == 0) ? 0 : j - 1;
        localparam int          UPPER = (j == N - 1) ? N - 1 : j + 1;
        localparam logic [IW-1:0] JI  = IW'(j);
        logic [W-1:0] pick;

        always_comb begin
            pick = gene[j];
            if (active) begin
                if (JI == ins_idx) begin
                    pick = lifted;
                end else if (toward_back && (JI > ins_idx) && (JI <= rem_idx)) begin
                    pick = gene[LOWER];
                end else if (!toward_back && (JI >= rem_idx) && (JI < ins_idx)) begin
                    pick = gene[UPPER];
                end
            end
        end

        assign chrom_out[j*W +: W] = pick;
    end
endmodule

// File: rtl/perm_move_mutator.sv
module perm_move_mutator #(
    parameter int N  = 8,
    parameter int W  = 3,
    parameter int PW = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           enable,
    input  logic [PW-1:0]  rem_pos,
    input  logic [PW-1:0]  ins_pos,
    input  logic [N*W-1:0] chrom_in,
    output logic [N*W-1:0] chrom_out,
    output logic           valid
);
    import pmm_pkg::*;

    localparam int IW = $clog2(N);

    pmm_state_t     state_q;
    pmm_state_t     state_d;
    logic           active;
    logic [IW-1:0]  rem_idx;
    logic [IW-1:0]  ins_idx;
    logic [N*W-1:0] moved;

    pmm_pos_decode #(.N(N), .PW(PW), .IW(IW)) u_decode (
        .rem_pos (rem_pos),
        .ins_pos (ins_pos),
        .enable  (enable),
        .active  (active),
        .rem_idx (rem_idx),
        .ins_idx (ins_idx)
    );

    pmm_shift_net #(.N(N), .W(W), .IW(IW)) u_shift (
        .chrom_in  (chrom_in),
        .active    (active),
        .rem_idx   (rem_idx),
        .ins_idx   (ins_idx),
        .chrom_out (moved)
    );

    // next state: IDLE_TO_SHOW / SHOW_TO_SHOW on start, else SHOW_TO_IDLE / IDLE_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = start ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     chrom_out <= '0;
        else if (start) chrom_out <= moved;
    end

    assign valid = (state_q == ST_SHOW);

    logic [W-1:0] gin  [N];
    logic [W-1:0] gout [N];
    for (genvar g = 0; g < N; g++) begin : g_view
        assign gin[g]  = chrom_in[g*W +: W];
        assign gout[g] = chrom_out[g*W +: W];
    end

    p_valid_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    p_valid_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(chrom_out));
    // R4 and R6 also reach this pass-through path
    p_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active) |=> (chrom_out == $past(chrom_in)));
    // R2 / R3: the lifted gene lands at the insertion slot
    p_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && active) |=> (gout[$past(ins_idx)] == $past(gin[rem_idx])));
endmodule

// File: tb/test_perm_move_mutator.sv
module test_perm_move_mutator;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int W  = 3;
    localparam int PW = 4;
    localparam int NV = 13;

    typedef struct packed {
        logic          en;
        logic [PW-1:0] rp;
        logic [PW-1:0] ip;
        logic [N*W-1:0] ci;
        logic [N*W-1:0] ce;
    } vec_t;

    // genes listed from position 1 to position 8; position 1 is the LSB field (R1)
    function automatic logic [N*W-1:0] mk(int a, int b, int c, int d, int e, int f, int g, int h);
        return {3'(h), 3'(g), 3'(f), 3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
    endfunction

    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd6, 4'd3, mk(1,7,3,2,0,4,6,5), mk(1,7,4,3,2,0,6,5)},  // R2
        '{1'b1, 4'd2, 4'd6, mk(1,7,3,2,0,4,6,5), mk(1,3,2,0,4,7,6,5)},  // R3
        '{1'b1, 4'd8, 4'd1, mk(0,1,2,3,4,5,6,7), mk(7,0,1,2,3,4,5,6)},  // R2 ends
        '{1'b1, 4'd1, 4'd8, mk(0,1,2,3,4,5,6,7), mk(1,2,3,4,5,6,7,0)},  // R3 ends
        '{1'b1, 4'd4, 4'd3, mk(0,1,2,3,4,5,6,7), mk(0,1,3,2,4,5,6,7)},  // R2 adjacent
        '{1'b1, 4'd3, 4'd4, mk(0,1,2,3,4,5,6,7), mk(0,1,3,2,4,5,6,7)},  // R3 adjacent
        '{1'b1, 4'd5, 4'd5, mk(3,1,4,0,5,2,7,6), mk(3,1,4,0,5,2,7,6)},  // R4
        '{1'b0, 4'd6, 4'd3, mk(1,7,3,2,0,4,6,5), mk(1,7,3,2,0,4,6,5)},  // R5
        '{1'b1, 4'd0, 4'd3, mk(0,1,2,3,4,5,6,7), mk(0,1,2,3,4,5,6,7)},  // R6
        '{1'b1, 4'd9, 4'd2, mk(0,1,2,3,4,5,6,7), mk(0,1,2,3,4,5,6,7)},  // R6
        '{1'b1, 4'd2, 4'd15, mk(0,1,2,3,4,5,6,7), mk(0,1,2,3,4,5,6,7)}, // R6
        '{1'b1, 4'd4, 4'd0, mk(6,5,4,3,2,1,0,7), mk(6,5,4,3,2,1,0,7)},  // R6
        '{1'b1, 4'd2, 4'd1, mk(5,6,7,0,1,2,3,4), mk(6,5,7,0,1,2,3,4)}   // R1
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           enable = 1'b0;
    logic [PW-1:0]  rem_pos = '0;
    logic [PW-1:0]  ins_pos = '0;
    logic [N*W-1:0] chrom_in = '0;
    logic [N*W-1:0] chrom_out;
    logic           valid;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    perm_move_mutator #(.N(N), .W(W), .PW(PW)) i_perm_move_mutator (
        .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
        .rem_pos(rem_pos), .ins_pos(ins_pos), .chrom_in(chrom_in),
        .chrom_out(chrom_out), .valid(valid)
    );

    task automatic check(string req, logic [N*W-1:0] act, logic [N*W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic is_perm(logic [N*W-1:0] c);
        logic [N-1:0] seen = '0;
        for (int k = 0; k < N; k++) seen[c[k*W +: W]] = 1'b1;
        return &seen;
    endfunction

    task automatic apply(logic en, logic [PW-1:0] rp, logic [PW-1:0] ip, logic [N*W-1:0] ci);
        @(negedge clk);
        enable = en; rem_pos = rp; ins_pos = ip; chrom_in = ci; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R7: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 reset valid", {23'd0, valid}, '0);
        check("R7 reset chrom_out", chrom_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle valid", {23'd0, valid}, '0);

        for (int v = 0; v < NV; v++) begin
            apply(VECS[v].en, VECS[v].rp, VECS[v].ip, VECS[v].ci);
            check($sformatf("R1-table vector %0d (R2 R3 R4 R5 R6)", v), chrom_out, VECS[v].ce);
            check($sformatf("R7 valid vector %0d", v), {23'd0, valid}, 24'd1);
            check($sformatf("R9 permutation vector %0d", v), {23'd0, is_perm(chrom_out)}, 24'd1);
        end

        // R7: valid falls the cycle after a lone start
        @(negedge clk);
        check("R7 valid low after pulse", {23'd0, valid}, '0);

        // R8: inputs change without start, output held
        apply(1'b1, 4'd6, 4'd3, mk(1,7,3,2,0,4,6,5));
        enable = 1'b1; rem_pos = 4'd1; ins_pos = 4'd8; chrom_in = mk(0,1,2,3,4,5,6,7);
        repeat (3) @(negedge clk);
        check("R8 hold without start", chrom_out, mk(1,7,4,3,2,0,6,5));
        check("R8 valid low while held", {23'd0, valid}, '0);

        // R7: back-to-back starts keep valid high, each result taken
        @(negedge clk);
        enable = 1'b1; rem_pos = 4'd8; ins_pos = 4'd1; chrom_in = mk(0,1,2,3,4,5,6,7); start = 1'b1;
        @(negedge clk);
        check("R7 first of pair valid", {23'd0, valid}, 24'd1);
        check("R2 first of pair", chrom_out, mk(7,0,1,2,3,4,5,6));
        rem_pos = 4'd1; ins_pos = 4'd8;
        @(negedge clk);
        start = 1'b0;
        check("R7 second of pair valid", {23'd0, valid}, 24'd1);
        check("R3 second of pair", chrom_out, mk(1,2,3,4,5,6,7,0));
        @(negedge clk);
        check("R7 valid low after pair", {23'd0, valid}, '0);

        // R7: reset mid-run clears the output
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset clears chrom_out", chrom_out, '0);
        check("R7 reset clears valid", {23'd0, valid}, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule